// File: doc/BRIEF.md
# Wake-on-LAN Pattern Frame Matcher

This block watches the byte stream of received Ethernet frames and decides whether a frame is a wake frame. It has three pattern channels that run side by side. Each channel has an enable, a 128-bit byte mask, an 8-bit start offset and a 16-bit CRC reference. For every byte of the frame, a channel checks whether that byte falls inside its window and whether the mask bit for it is set. Selected bytes are folded into that channel's CRC-16. At a good frame end, each enabled channel compares its CRC with its reference.

Any match raises a sticky wake-frame status bit. A change on the link-status input raises a separate sticky bit. Software clears both bits with a read strobe. All configuration arrives on plain register inputs. It only needs to hold steady while a frame is being received.

Top module: `wol_match_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, `pat_hit`, `wake_frame` and `link_change` are all 0.
- R2: The CRC-16 uses polynomial x^16+x^15+x^2+1 and takes each byte least significant bit first, with no final inversion. With a zero seed, a single selected byte 0x01 gives 0xC0C1.
- R3: When `crc_seed_ones` is 1, the CRC starts from 0xFFFF; when it is 0, it starts from 0x0000. A channel with an all-zero mask therefore ends with exactly the seed value.
- R4: Mask bit i of a channel selects frame byte number offset+i, counting the first byte of the frame as byte 0. Bytes that are not selected have no effect on the result.
- R5: Mask bits that point past the last byte of the frame are ignored. The CRC covers only the selected bytes that the frame actually contains.
- R6: A channel whose enable bit is 0 never reports a hit, whatever its reference value.
- R7: A hit can only follow a frame end (`rx_valid` and `rx_last` both 1) with `rx_crc_err` at 0. A frame end flagged with a CRC error gives no hit on any channel.
- R8: The three channels are independent. `pat_hit[k]` is 1 for exactly the one cycle after the last byte of a frame whose channel-k CRC equals its reference. Idle cycles with `rx_valid` at 0 may fall inside a frame.
- R9: `wake_frame` goes to 1 on the cycle after any `pat_hit` bit is 1 and then holds. A `stat_rd` pulse clears it on the next cycle. If a hit arrives on the same cycle as the read, the bit stays set.
- R10: `link_change` goes to 1 on the cycle after `link_up` differs from its value one cycle earlier. It holds until `stat_rd`, with the same rule as R9 that a new event wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte is the final byte of the frame |
| rx_crc_err | input | 1 | Frame check failed; sampled with the final byte |
| pat_en | input | 3 | Enable for each pattern channel |
| pat_mask | input | 384 | Byte masks, 128 bits per channel; channel k uses bits [128k+127:128k] |
| pat_offset | input | 24 | Start offsets, 8 bits per channel |
| pat_crc | input | 48 | CRC references, 16 bits per channel |
| crc_seed_ones | input | 1 | 1 selects a seed of 0xFFFF, 0 selects 0x0000 |
| link_up | input | 1 | Current link status |
| stat_rd | input | 1 | Status read strobe; clears both sticky bits |
| pat_hit | output | 3 | One-cycle match pulse for each channel |
| wake_frame | output | 1 | Sticky wake-frame status |
| link_change | output | 1 | Sticky link-change status |

## Verification
The assertions assume that every frame ends with a byte carrying `rx_last` before any later frame begins. They also assume that `rx_crc_err` means something only on that final byte, and that configuration does not change between the first and last byte of a frame. The stimulus changes masks, offsets, references, enables and the seed only while the byte stream is idle. It raises the error flag only together with `rx_last`, and it places random idle gaps inside frames without ever splitting a frame across a reset.

// File: rtl/wol_pkg.sv
package wol_pkg;
    localparam int N_PAT     = 3;
    localparam int MASK_BITS = 128;
    localparam int OFF_W     = 8;
    localparam int CRC_W     = 16;
    localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic       err;
        logic [7:0] data;
    } rx_beat_t;

    function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c_in,
                                                    input logic [7:0] d);
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [CRC_W-1:0] crc_seed(input logic ones);
        return ones ? {CRC_W{1'b1}} : {CRC_W{1'b0}};
    endfunction
endpackage

// File: rtl/wol_pattern_chan.sv
module wol_pattern_chan
    import wol_pkg::*;
#(
    parameter int MASK_BITS = wol_pkg::MASK_BITS,
    parameter int OFF_W     = wol_pkg::OFF_W,
    parameter int POS_W     = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rx_beat_t             beat,
    input  logic [POS_W-1:0]     pos,
    input  logic                 en,
    input  logic [MASK_BITS-1:0] mask,
    input  logic [OFF_W-1:0]     offset,
    input  logic [CRC_W-1:0]     ref_crc,
    input  logic                 seed_ones,
    output logic                 hit
);
    localparam int IDX_W = $clog2(MASK_BITS);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_start;
    logic [CRC_W-1:0] crc_next;
    logic [POS_W-1:0] rel;
    logic             in_window;
    logic             selected;

    always_comb begin
        rel       = pos - POS_W'(offset);
        in_window = (pos >= POS_W'(offset)) && (rel < POS_W'(MASK_BITS));
        selected  = in_window && mask[rel[IDX_W-1:0]];
        crc_start = (pos == '0) ? crc_seed(seed_ones) : crc_q;
        crc_next  = selected ? crc16_byte(crc_start, beat.data) : crc_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
            hit   <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (beat.valid) begin
                crc_q <= crc_next;
                if (beat.last)
                    hit <= en && !beat.err && (crc_next == ref_crc);
            end
        end
    end
endmodule

// File: rtl/wol_wake_status.sv
module wol_wake_status (
    input  logic clk,
    input  logic rst,
    input  logic hit_any,
    input  logic link_up,
    input  logic stat_rd,
    output logic wake_frame,
    output logic link_change
);
    logic link_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_frame  <= 1'b0;
            link_change <= 1'b0;
            link_q      <= link_up;
        end else begin
            link_q      <= link_up;
            wake_frame  <= hit_any | (wake_frame & ~stat_rd);
            link_change <= (link_up ^ link_q) | (link_change & ~stat_rd);
        end
    end
endmodule

// File: rtl/wol_match_top.sv
module wol_match_top
    import wol_pkg::*;
#(
    parameter int N_PAT     = wol_pkg::N_PAT,
    parameter int MASK_BITS = wol_pkg::MASK_BITS,
    parameter int OFF_W     = wol_pkg::OFF_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_data,
    input  logic                       rx_last,
    input  logic                       rx_crc_err,
    input  logic [N_PAT-1:0]           pat_en,
    input  logic [N_PAT*MASK_BITS-1:0] pat_mask,
    input  logic [N_PAT*OFF_W-1:0]     pat_offset,
    input  logic [N_PAT*CRC_W-1:0]     pat_crc,
    input  logic                       crc_seed_ones,
    input  logic                       link_up,
    input  logic                       stat_rd,
    output logic [N_PAT-1:0]           pat_hit,
    output logic                       wake_frame,
    output logic                       link_change
);
    localparam int POS_W = $clog2((1 << OFF_W) + MASK_BITS) + 1;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    rx_beat_t         beat;
    logic [POS_W-1:0] pos_q;

    assign beat = '{valid: rx_valid, last: rx_last, err: rx_crc_err, data: rx_data};

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (beat.valid) begin
            if (beat.last)              pos_q <= '0;
            else if (pos_q != POS_MAX)  pos_q <= pos_q + 1'b1;
        end
    end

    for (genvar k = 0; k < N_PAT; k++) begin : g_chan
        wol_pattern_chan #(
            .MASK_BITS(MASK_BITS),
            .OFF_W    (OFF_W),
            .POS_W    (POS_W)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .beat     (beat),
            .pos      (pos_q),
            .en       (pat_en[k]),
            .mask     (pat_mask[k*MASK_BITS +: MASK_BITS]),
            .offset   (pat_offset[k*OFF_W +: OFF_W]),
            .ref_crc  (pat_crc[k*CRC_W +: CRC_W]),
            .seed_ones(crc_seed_ones),
            .hit      (pat_hit[k])
        );
    end

    wol_wake_status u_status (
        .clk        (clk),
        .rst        (rst),
        .hit_any    (|pat_hit),
        .link_up    (link_up),
        .stat_rd    (stat_rd),
        .wake_frame (wake_frame),
        .link_change(link_change)
    );
endmodule

// File: rtl/wol_match_checker.sv
module wol_match_checker #(
    parameter int N_PAT = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_last,
    input logic             rx_crc_err,
    input logic [N_PAT-1:0] pat_en,
    input logic             link_up,
    input logic             stat_rd,
    input logic [N_PAT-1:0] pat_hit,
    input logic             wake_frame,
    input logic             link_change
);
    for (genvar k = 0; k < N_PAT; k++) begin : g_chk
        p_hit_good_end_r7: assert property (@(posedge clk) disable iff (rst)
            pat_hit[k] |-> $past(rx_valid && rx_last && !rx_crc_err));
        p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
            pat_hit[k] |-> $past(pat_en[k]));
    end

    p_wake_follows_hit_r9: assert property (@(posedge clk) disable iff (rst)
        (|pat_hit) |=> wake_frame);
    p_wake_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_frame) |-> $past(|pat_hit));
    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_rd) && !$past(|pat_hit)) |-> !wake_frame);
    p_link_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(link_change) |-> ($past(link_up) != $past(link_up, 2)));
endmodule

bind wol_match_top wol_match_checker #(.N_PAT(N_PAT)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_last    (rx_last),
    .rx_crc_err (rx_crc_err),
    .pat_en     (pat_en),
    .link_up    (link_up),
    .stat_rd    (stat_rd),
    .pat_hit    (pat_hit),
    .wake_frame (wake_frame),
    .link_change(link_change)
);

// File: tb/wol_match_top_test.sv
module wol_match_top_test;
    localparam int NP = 3;
    localparam int MB = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [NP-1:0] pat_en = '0;
    logic crc_seed_ones = 1'b0, link_up = 1'b0, stat_rd = 1'b0;
    logic [MB-1:0] msk [NP];
    logic [7:0]    offs [NP];
    logic [15:0]   refv [NP];
    logic [NP*MB-1:0] pat_mask;
    logic [NP*8-1:0]  pat_offset;
    logic [NP*16-1:0] pat_crc;
    logic [NP-1:0] pat_hit;
    logic wake_frame, link_change;
    logic [7:0] fbuf [256];

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NP; k++) begin
            pat_mask[k*MB +: MB]  = msk[k];
            pat_offset[k*8 +: 8]  = offs[k];
            pat_crc[k*16 +: 16]   = refv[k];
        end
    end

    wol_match_top uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_crc_err(rx_crc_err), .pat_en(pat_en),
        .pat_mask(pat_mask), .pat_offset(pat_offset), .pat_crc(pat_crc),
        .crc_seed_ones(crc_seed_ones), .link_up(link_up), .stat_rd(stat_rd),
        .pat_hit(pat_hit), .wake_frame(wake_frame), .link_change(link_change)
    );

    // Reference CRC per R2/R3/R4/R5: reflected poly A001, LSB first
    function automatic logic [15:0] model_crc(int k, int len, logic ones);
        logic [15:0] c = ones ? 16'hFFFF : 16'h0000;
        for (int p = 0; p < len; p++) begin
            int r = p - int'(offs[k]);
            if (r >= 0 && r < MB && msk[k][r]) begin
                for (int b = 0; b < 8; b++) begin
                    logic fb = c[0] ^ fbuf[p][b];
                    c = {1'b0, c[15:1]};
                    if (fb) c = c ^ 16'hA001;
                end
            end
        end
        return c;
    endfunction

    function automatic logic [NP-1:0] model_hits(int len, logic err);
        logic [NP-1:0] h = '0;
        for (int k = 0; k < NP; k++)
            h[k] = pat_en[k] && !err && (model_crc(k, len, crc_seed_ones) == refv[k]);
        return h;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Ends at the negedge after the edge that took the last byte.
    task automatic send_frame(input int len, input logic err, input bit gaps);
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            while (gaps && ($urandom % 4 == 0)) begin
                rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_data = fbuf[p];
            rx_last = (p == len - 1);
            rx_crc_err = err && (p == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0;
    endtask

    task automatic clear_status();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_checked(input string tag, input int len, input logic err);
        logic [NP-1:0] e = model_hits(len, err);
        send_frame(len, err, 1'b1);
        chk({tag, " R8 hits"}, 32'(pat_hit), 32'(e));
        @(negedge clk);
        chk({tag, " R8 pulse ends"}, 32'(pat_hit), 32'(0));
        chk({tag, " R9 wake set"}, 32'(wake_frame), 32'(|e));
        clear_status();
        chk({tag, " R9 wake cleared"}, 32'(wake_frame), 32'(0));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NP; k++) begin msk[k] = '0; offs[k] = '0; refv[k] = '0; end
        for (int i = 0; i < 256; i++) fbuf[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        chk("R1 reset hit", 32'(pat_hit), 0);
        chk("R1 reset wake", 32'(wake_frame), 0);
        chk("R1 reset link", 32'(link_change), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset wake/link", 32'({wake_frame, link_change, pat_hit}), 0);

        // R2 known vector: one byte 0x01 -> C0C1
        fbuf[0] = 8'h01; msk[0] = 128'h1; offs[0] = 8'd0; refv[0] = 16'hC0C1;
        pat_en = 3'b001; crc_seed_ones = 1'b0;
        send_frame(1, 1'b0, 1'b0);
        chk("R2 known vector hit", 32'(pat_hit), 32'h1);
        @(negedge clk); clear_status();

        // R3 empty mask ends at seed
        msk[0] = '0; msk[1] = '0; refv[0] = 16'hFFFF; refv[1] = 16'h0000;
        pat_en = 3'b011; crc_seed_ones = 1'b1;
        send_frame(5, 1'b0, 1'b0);
        chk("R3 seed ones", 32'(pat_hit), 32'h1);
        @(negedge clk); clear_status();
        crc_seed_ones = 1'b0;
        send_frame(5, 1'b0, 1'b0);
        chk("R3 seed zeros", 32'(pat_hit), 32'h2);
        @(negedge clk); clear_status();

        // R5 mask runs past frame end
        for (int i = 0; i < 256; i++) fbuf[i] = 8'($urandom);
        msk[2] = '1; offs[2] = 8'd5; pat_en = 3'b100;
        refv[2] = model_crc(2, 10, 1'b0);
        run_checked("R5 past end", 10, 1'b0);

        // R4 an unselected byte changes, result unchanged
        msk[2] = 128'h5; offs[2] = 8'd2;
        refv[2] = model_crc(2, 12, 1'b0);
        fbuf[3] = ~fbuf[3]; fbuf[0] = ~fbuf[0];
        send_frame(12, 1'b0, 1'b1);
        chk("R4 unselected ignored", 32'(pat_hit), 32'h4);
        @(negedge clk); clear_status();

        // R6 disabled channel with correct reference
        pat_en = 3'b000;
        send_frame(12, 1'b0, 1'b1);
        chk("R6 disabled no hit", 32'(pat_hit), 0);
        @(negedge clk);
        chk("R6 no wake", 32'(wake_frame), 0);

        // R7 CRC error frame
        pat_en = 3'b100;
        send_frame(12, 1'b1, 1'b1);
        chk("R7 crc error no hit", 32'(pat_hit), 0);
        @(negedge clk);

        // R9 read on same cycle as hit: set wins
        send_frame(12, 1'b0, 1'b0);
        chk("R9 hit before read", 32'(pat_hit), 32'h4);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R9 set wins over read", 32'(wake_frame), 1);
        clear_status();
        chk("R9 later read clears", 32'(wake_frame), 0);

        // R10 link change
        link_up = 1'b1;
        @(negedge clk);
        chk("R10 link change set", 32'(link_change), 1);
        @(negedge clk);
        chk("R10 link change sticky", 32'(link_change), 1);
        clear_status();
        chk("R10 read clears", 32'(link_change), 0);
        repeat (3) @(negedge clk);
        chk("R10 stable link quiet", 32'(link_change), 0);

        // Random frames: R2 R3 R4 R8 R9
        for (int it = 0; it < 40; it++) begin
            int len = 1 + ($urandom % 200);
            for (int i = 0; i < 256; i++) fbuf[i] = 8'($urandom);
            crc_seed_ones = 1'($urandom);
            pat_en = NP'($urandom);
            for (int k = 0; k < NP; k++) begin
                msk[k] = {$urandom, $urandom, $urandom, $urandom};
                offs[k] = 8'($urandom % 64);
                if ($urandom % 2) refv[k] = model_crc(k, len, crc_seed_ones);
                else              refv[k] = 16'($urandom);
            end
            run_checked("random", len, 1'b0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule